// File: doc/BRIEF.md
# Control-Line Logic Analyzer

This block is a diagnostic that watches a fixed group of control lines. It gives two views of them. The first is a snapshot register that always holds the present state of the lines. The second is a capture memory. Once the block is armed, it waits for a trigger and then records the lines on every clock for a fixed number of samples. It then stops and raises a done flag.

The trigger source is chosen through a control register. It can be a rising edge on any monitored line, an external trigger pin, a readout-abort pin, or a software force bit. A plain register port stands in for the host bus. Writes set the trigger source, arm the block and force a trigger. Reads return the snapshot, the status word, the control setting or one stored sample, selected by address. Every read has one cycle of latency.

The default depth is 4096 samples. At a 53 MHz sample clock this covers roughly 77 µs after the trigger.

Top module: `ctrl_line_analyzer`

## Requirements
- R1: A read of the snapshot register (address 0) returns the monitored lines as registered on the clock edge before the read edge. The lines pass through one register stage, so `rd_data` changes one cycle after `lines_in` does.
- R2: Control bits [1:0] select the trigger source: 0 is a rising edge on any monitored line, 1 is `ext_trig` high, 2 is `abort_in` high, and 3 is a control write with bit 3 set (software force).
- R3: A trigger is accepted only while the block is armed, and a control write with bit 2 set arms it. An unarmed block ignores every trigger source.
- R4: Capture stores DEPTH consecutive samples of the lines, one per clock. For sources 1, 2 and 3, sample 0 is the value of the lines at the edge on which the trigger is seen.
- R5: When the last sample is written, the block shows done=1, capturing=0 and count=DEPTH. It then ignores triggers and keeps its memory unchanged until it is re-armed. Re-arming clears done and sets count to 0.
- R6: The status word (address 1) has armed in bit 0, capturing in bit 1, done in bit 2, and the sample count in bits starting at bit 16. At most one of the three flags is set at any time.
- R7: Read addresses with the top address bit set return stored sample number addr[IDX_W-1:0]. Address 2 returns the trigger select. Every read has one cycle of latency.
- R8: An arm write during a capture is ignored, and the capture runs to completion.
- R9: After reset the status, the control setting and the snapshot are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_in | input | WIDTH | Monitored control lines |
| ext_trig | input | 1 | External trigger, active high |
| abort_in | input | 1 | Readout-abort trigger, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | IDX_W+1 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | IDX_W+1 | Read address, for a register or a stored sample |
| rd_data | output | DATA_W | Read data, one cycle after `rd_addr` |

## Verification
A vector table runs a capture for each trigger source in turn.

- For sources 1, 2 and 3, the lines ramp from the trigger edge onward. The stored ramp therefore shows that sample 0 lands on the trigger edge and that no cycle is skipped.
- For the rising-edge source, the lines step up once. A constant stored value shows that the step itself started the capture.
- Some vectors drive a non-selected source and expect the block to stay armed. These tell a correct source select apart from an OR of all sources.

Directed tests then fire triggers before arming and after done, and write an arm bit during a capture. Status and memory readback are used to separate "ignored" from "restarted".

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_CAP, ST_DONE} cla_state_e;

  localparam logic [1:0] TSEL_RISE  = 2'd0;
  localparam logic [1:0] TSEL_EXT   = 2'd1;
  localparam logic [1:0] TSEL_ABORT = 2'd2;
  localparam logic [1:0] TSEL_SOFT  = 2'd3;

  localparam int REG_SNAP = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CTRL = 2;

  localparam int CTRL_ARM_BIT   = 2;
  localparam int CTRL_FORCE_BIT = 3;
  localparam int STAT_CNT_LSB   = 16;
endpackage

// File: rtl/cla_trigger.sv
module cla_trigger
  import cla_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lines_in,
  input  logic             ext_trig,
  input  logic             abort_in,
  input  logic             soft_force,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] snap,
  output logic             trig
);
  logic [WIDTH-1:0] snap_q, prev_q;
  logic             any_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      prev_q <= '0;
    end else begin
      snap_q <= lines_in;
      prev_q <= snap_q;
    end
  end

  assign any_rise = |(snap_q & ~prev_q);
  assign snap     = snap_q;

  always_comb begin
    case (sel)
      TSEL_RISE:  trig = any_rise;
      TSEL_EXT:   trig = ext_trig;
      TSEL_ABORT: trig = abort_in;
      default:    trig = soft_force;
    endcase
  end
endmodule

// File: rtl/cla_ctrl.sv
module cla_ctrl
  import cla_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_wr,
  input  logic             trig,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_widx,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             capturing,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

  cla_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE:
          if (arm_wr) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
          end
        ST_ARMED:
          if (trig) begin
            state_q <= ST_CAP;
            cnt_q   <= '0;
          end
        ST_CAP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_DONE;
        end
        default:
          if (arm_wr) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
          end
      endcase
    end
  end

  assign armed     = (state_q == ST_ARMED);
  assign capturing = (state_q == ST_CAP);
  assign done      = (state_q == ST_DONE);
  assign mem_we    = capturing;
  assign mem_widx  = cnt_q[IDX_W-1:0];
  assign cnt       = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R5
  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capturing) |-> $past(armed) && $past(trig)); // R3
  AST_CAP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    capturing && $past(capturing) |-> cnt_q == $past(cnt_q) + 1'b1); // R4
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cnt_q == CNT_W'(DEPTH)); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !arm_wr |=> done && $stable(cnt_q)); // R5
  AST_ARM_IN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    capturing && arm_wr |=> capturing || done); // R8
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, capturing, done})); // R6
endmodule

// File: rtl/cla_store.sv
module cla_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4096,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/ctrl_line_analyzer.sv
module ctrl_line_analyzer
  import cla_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 4096,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  lines_in,
  input  logic              ext_trig,
  input  logic              abort_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic              ctrl_wr, arm_wr, soft_force, trig;
  logic [1:0]        sel_q;
  logic [WIDTH-1:0]  snap, mem_q;
  logic              mem_we, armed, capturing, done;
  logic [IDX_W-1:0]  mem_widx;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] stat_w, reg_mux, reg_q;
  logic              rd_mem_q;

  assign ctrl_wr    = wr_en && !wr_addr[ADDR_W-1] && (wr_addr[IDX_W-1:0] == IDX_W'(REG_CTRL));
  assign arm_wr     = ctrl_wr && wr_data[CTRL_ARM_BIT];
  assign soft_force = ctrl_wr && wr_data[CTRL_FORCE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= TSEL_RISE;
    else if (ctrl_wr) sel_q <= wr_data[1:0];
  end

  cla_trigger #(.WIDTH(WIDTH)) u_trig (
    .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .ext_trig(ext_trig),
    .abort_in(abort_in), .soft_force(soft_force), .sel(sel_q),
    .snap(snap), .trig(trig)
  );

  cla_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .trig(trig),
    .mem_we(mem_we), .mem_widx(mem_widx), .cnt(cnt),
    .armed(armed), .capturing(capturing), .done(done)
  );

  cla_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(mem_we), .widx(mem_widx), .wdata(snap),
    .ridx(rd_addr[IDX_W-1:0]), .rdata(mem_q)
  );

  always_comb begin
    stat_w    = '0;
    stat_w[0] = armed;
    stat_w[1] = capturing;
    stat_w[2] = done;
    stat_w[STAT_CNT_LSB +: CNT_W] = cnt;
  end

  always_comb begin
    case (rd_addr[IDX_W-1:0])
      IDX_W'(REG_SNAP): reg_mux = DATA_W'(snap);
      IDX_W'(REG_STAT): reg_mux = stat_w;
      IDX_W'(REG_CTRL): reg_mux = DATA_W'(sel_q);
      default:          reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q    <= '0;
      rd_mem_q <= 1'b0;
    end else begin
      reg_q    <= reg_mux;
      rd_mem_q <= rd_addr[ADDR_W-1];
    end
  end

  assign rd_data = rd_mem_q ? DATA_W'(mem_q) : reg_q;

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(sel_q)); // R2
  AST_STORE_ONLY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !armed && !done); // R5
endmodule

// File: tb/tb_ctrl_line_analyzer.sv
`timescale 1ns/1ps
module tb_ctrl_line_analyzer;
  localparam int WIDTH = 8;
  localparam int DEPTH = 16;
  localparam int DW    = 32;
  localparam int AW    = $clog2(DEPTH) + 1;
  localparam logic [DW-1:0] ST_DONE_W = 32'h0010_0004;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WIDTH-1:0] lines_in = '0;
  logic          ext_trig = 1'b0, abort_in = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ctrl_line_analyzer #(.WIDTH(WIDTH), .DEPTH(DEPTH), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .ext_trig(ext_trig),
    .abort_in(abort_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {sel[4:3], stim[2:1], expect_capture[0]}; stim: 0 rise, 1 ext, 2 abort, 3 force
  localparam logic [4:0] VEC [7] = '{
    {2'd0, 2'd0, 1'b1}, {2'd1, 2'd1, 1'b1}, {2'd2, 2'd2, 1'b1},
    {2'd3, 2'd3, 1'b1}, {2'd1, 2'd2, 1'b0}, {2'd2, 2'd1, 1'b0},
    {2'd3, 2'd1, 1'b0}
  };

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int addr, output logic [DW-1:0] v);
    @(negedge clk);
    rd_addr = AW'(addr);
    @(posedge clk);
    #1 v = rd_data;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; lines_in = '0; ext_trig = 0; abort_in = 0; wr_en = 0;
    run_cycles(3);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [DW-1:0] v;
    logic [1:0] sel, stim;
    bit expc;
    do_reset();

    // Vector table: each trigger source, selected and non-selected (R2, R4, R5, R3)
    for (int n = 0; n < 7; n++) begin
      {sel, stim, expc} = VEC[n];
      lines_in = '0;
      reg_wr(2, DW'(sel) | 32'h4);
      run_cycles(2);
      case (stim)
        2'd0: lines_in = 8'h80;
        2'd1: ext_trig = 1'b1;
        2'd2: abort_in = 1'b1;
        default: begin wr_en = 1'b1; wr_addr = AW'(2); wr_data = 32'h8 | DW'(sel); end
      endcase
      for (int k = 1; k <= DEPTH + 4; k++) begin
        @(negedge clk);
        ext_trig = 0; abort_in = 0; wr_en = 0;
        lines_in = (stim == 2'd0) ? 8'h80 : WIDTH'(k);
      end
      reg_rd(1, v);
      if (expc) begin
        check($sformatf("R5 R6 status after capture vec%0d", n), v, ST_DONE_W);
        for (int i = 0; i < DEPTH; i++) begin
          reg_rd(DEPTH + i, v);
          check($sformatf("R4 R7 sample %0d vec%0d", i, n), v,
                (stim == 2'd0) ? 32'h80 : DW'(i));
        end
      end else begin
        check($sformatf("R2 unselected source ignored vec%0d", n), v, 32'h1);
      end
      reg_rd(2, v);
      check($sformatf("R7 ctrl readback vec%0d", n), v, DW'(sel));
    end

    // R9: reset state
    lines_in = '0;
    do_reset();
    reg_rd(1, v); check("R9 status after reset", v, 32'h0);
    reg_rd(2, v); check("R9 ctrl after reset", v, 32'h0);
    reg_rd(0, v); check("R9 snapshot after reset", v, 32'h0);

    // R1: snapshot follows lines with one register stage
    lines_in = 8'hA5; run_cycles(2);
    reg_rd(0, v); check("R1 snapshot steady", v, 32'hA5);
    @(negedge clk); lines_in = 8'h3C; rd_addr = AW'(0);
    @(posedge clk); #1 v = rd_data; check("R1 snapshot one stage late", v, 32'hA5);
    reg_rd(0, v); check("R1 snapshot updated", v, 32'h3C);

    // R3: unarmed block ignores the trigger
    lines_in = '0;
    reg_wr(2, 32'h1);
    @(negedge clk); ext_trig = 1; @(negedge clk); ext_trig = 0;
    run_cycles(DEPTH + 2);
    reg_rd(1, v); check("R3 unarmed trigger ignored", v, 32'h0);

    // R8: arm write during capture is ignored
    reg_wr(2, 32'h5);
    @(negedge clk); ext_trig = 1; lines_in = 8'h00;
    @(negedge clk); ext_trig = 0;
    run_cycles(3);
    reg_wr(2, 32'h5);
    reg_rd(1, v); check("R8 still capturing after arm write", {30'b0, v[1:0]}, 32'h2);
    run_cycles(DEPTH);
    reg_rd(1, v); check("R8 capture completes", v, ST_DONE_W);
    reg_rd(DEPTH, v); check("R8 sample 0 kept", v, 32'h0);

    // R5: triggers after done are ignored, memory unchanged
    lines_in = 8'hFF;
    @(negedge clk); ext_trig = 1; @(negedge clk); ext_trig = 0;
    run_cycles(DEPTH + 2);
    reg_rd(1, v); check("R5 done holds against trigger", v, ST_DONE_W);
    reg_rd(DEPTH, v); check("R5 memory unchanged after done", v, 32'h0);

    // R5: re-arm clears done and count
    reg_wr(2, 32'h5);
    reg_rd(1, v); check("R5 re-arm status", v, 32'h1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule